// File: doc/BRIEF.md
# Coax Modem Direction Controller

This block is the mode controller of an on-off-keyed coaxial modem. It sits between the baseband serial lines and the RF front end. It watches two kinds of activity: the local transmit line (`txIn`, idle high, low for a 0 bit) and a carrier-detect flag from the receive path (`carrierDet`, high while carrier is on the line). From these it decides whether the node is idle, receiving or transmitting. The result drives `dirOut`, which goes to the enable pin of an RS-485 transceiver, and `rxOut`, the gated receive data line. The block also produces the keyed transmit carrier at one quarter of the reference clock.

The first activity seen in idle decides the mode, and that mode holds until sixteen bit periods pass with no further activity. The length of a bit period in reference-clock cycles comes from a two-bit select: code 00 is the slowest rate, 01 the middle rate and 10 the fastest. Code 11 puts the block in standby. In standby the transmit carrier is off and the receive data still follows the line. Short carrier bursts are filtered out before they count as data.

Top module: `coaxDirCtl`

## Requirements
- R1: After reset, and in idle with `txIn` high and no carrier, `dirOut` is 0, `rxOut` is 1 and `txCarrier` is 0; asserting `rstN` low forces these values at once.
- R2: A carrier burst shorter than `NOISE_CYC` consecutive clocks leaves `rxOut` at 1 and `dirOut` at 0.
- R3: From idle, carrier held for `NOISE_CYC` clocks puts the block in receive mode within `NOISE_CYC`+1 clocks, with `dirOut` = 1 and `rxOut` = 0. In receive mode `rxOut` returns to 1 one clock after the carrier drops.
- R4: In receive mode, `dirOut` stays 1 for 16 bit periods after `rxOut` last rose, and falls no more than 2 clocks later.
- R5: From idle, `txIn` going low puts the block in transmit mode on the next clock, with `dirOut` = 0; this takes priority over a carrier that appears in the same cycle.
- R6: In transmit mode `rxOut` stays 1 whatever `carrierDet` does.
- R7: Transmit mode lasts 16 bit periods after `txIn` last went high; a new low on `txIn` restarts that wait.
- R8: Outside standby, `txCarrier` is a square wave of period `CARRIER_DIV` clocks (4 by default) while `txIn` is low, and it is 0 from the clock after `txIn` is sampled high.
- R9: Select code 00 uses `BIT_CYC_SLOW`, code 01 uses `BIT_CYC_MID` and code 10 uses `BIT_CYC_FAST` clocks per bit for the timeout.
- R10: With select code 11 (standby), `txCarrier` and `dirOut` are 0 from the next clock regardless of `txIn`, and `rxOut` is the inverse of the noise-filtered carrier.
- R11: Leaving standby returns the block to idle on the next clock, with the timeout cleared; entering standby from receive mode drops `dirOut` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (carrier is one quarter of it) |
| rstN | input | 1 | Asynchronous active-low reset |
| txIn | input | 1 | Baseband transmit data, idle high |
| carrierDet | input | 1 | Raw carrier-present flag from the receive detector |
| rateSel | input | 2 | Bit-rate select; 11 selects standby |
| dirOut | output | 1 | Direction: 1 while receiving, 0 otherwise |
| rxOut | output | 1 | Gated receive data, low while valid carrier is present |
| txCarrier | output | 1 | Keyed transmit carrier |

## Verification
The properties assume that `txIn`, `carrierDet` and `rateSel` are synchronous to `clk` and change only between rising edges. They also assume that nothing is inferred in the first cycle after reset is released. The bench drives every input on the falling edge and holds it for whole clock cycles. It keeps `rstN` low for several cycles before any activity. It changes the select code only while the block is idle or in order to enter or leave standby. This means the rate tables are never switched in the middle of a timeout that a check depends on.

// File: rtl/coaxDirPkg.sv
package coaxDirPkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_RX   = 2'd1,
    MODE_TX   = 2'd2,
    MODE_STBY = 2'd3
  } modeT;

  // Strobes from control to datapath
  typedef struct packed {
    logic tmoClear;   // zero the inactivity counter
    logic tmoLoad;    // reload with 16 bit periods
    logic tmoRun;     // count down one step
    logic txEnable;   // let the carrier through
  } ctlStrobeT;

  localparam logic [1:0]  SEL_STANDBY      = 2'b11;
  localparam int unsigned BITS_PER_TIMEOUT = 16;

endpackage

// File: rtl/coaxDirDatapath.sv
module coaxDirDatapath
  import coaxDirPkg::*;
#(
  parameter int unsigned NOISE_CYC    = 8,
  parameter int unsigned BIT_CYC_SLOW = 907,
  parameter int unsigned BIT_CYC_MID  = 227,
  parameter int unsigned BIT_CYC_FAST = 76,
  parameter int unsigned CARRIER_DIV  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       carrierDet,
  input  logic [1:0] rateSel,
  input  ctlStrobeT  strobe,
  output logic       validCarrier,
  output logic       tmoDone,
  output logic       txCarrier
);

  localparam int unsigned PMAX_A  = (BIT_CYC_SLOW > BIT_CYC_MID) ? BIT_CYC_SLOW : BIT_CYC_MID;
  localparam int unsigned PMAX    = (PMAX_A > BIT_CYC_FAST) ? PMAX_A : BIT_CYC_FAST;
  localparam int unsigned TMO_MAX = BITS_PER_TIMEOUT * PMAX;
  localparam int unsigned TMO_W   = $clog2(TMO_MAX + 1);
  localparam int unsigned NF_W    = (NOISE_CYC > 1) ? $clog2(NOISE_CYC) : 1;
  localparam int unsigned DIV_W   = (CARRIER_DIV > 2) ? $clog2(CARRIER_DIV) : 1;
  localparam int unsigned DIV_HALF = CARRIER_DIV / 2;

  localparam logic [TMO_W-1:0] LOAD_SLOW = TMO_W'(BITS_PER_TIMEOUT * BIT_CYC_SLOW);
  localparam logic [TMO_W-1:0] LOAD_MID  = TMO_W'(BITS_PER_TIMEOUT * BIT_CYC_MID);
  localparam logic [TMO_W-1:0] LOAD_FAST = TMO_W'(BITS_PER_TIMEOUT * BIT_CYC_FAST);

  // ---------------- noise filter ----------------
  logic validQ;

  generate
    if (NOISE_CYC <= 1) begin : g_nfDirect
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= carrierDet;
      end
    end else begin : g_nfCount
      logic [NF_W-1:0] runCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          runCnt <= '0;
          validQ <= 1'b0;
        end else if (!carrierDet) begin
          runCnt <= '0;
          validQ <= 1'b0;
        end else if (runCnt == NF_W'(NOISE_CYC - 1)) begin
          validQ <= 1'b1;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end
    end
  endgenerate

  assign validCarrier = validQ;

  // ---------------- inactivity timeout ----------------
  logic [TMO_W-1:0] tmoCnt;
  logic [TMO_W-1:0] loadVal;

  always_comb begin
    case (rateSel)
      2'b00:   loadVal = LOAD_SLOW;
      2'b01:   loadVal = LOAD_MID;
      default: loadVal = LOAD_FAST;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          tmoCnt <= '0;
    else if (strobe.tmoClear)           tmoCnt <= '0;
    else if (strobe.tmoLoad)            tmoCnt <= loadVal;
    else if (strobe.tmoRun && tmoCnt != '0) tmoCnt <= tmoCnt - 1'b1;
  end

  assign tmoDone = (tmoCnt == '0);

  // ---------------- carrier divider ----------------
  logic [DIV_W-1:0] divCnt;
  logic             carrierPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  divCnt <= '0;
    else if (divCnt == DIV_W'(CARRIER_DIV - 1)) divCnt <= '0;
    else                                        divCnt <= divCnt + 1'b1;
  end

  assign carrierPhase = (divCnt >= DIV_W'(DIV_HALF));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txCarrier <= 1'b0;
    else       txCarrier <= strobe.txEnable & carrierPhase;
  end

endmodule

// File: rtl/coaxDirControl.sv
module coaxDirControl
  import coaxDirPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txIn,
  input  logic       validCarrier,
  input  logic       tmoDone,
  input  logic [1:0] rateSel,
  output ctlStrobeT  strobe,
  output logic       dirOut,
  output logic       rxOut
);

  modeT state, nextState;
  logic standbyReq;

  assign standbyReq = (rateSel == SEL_STANDBY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= MODE_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState       = state;
    strobe          = '0;
    strobe.txEnable = !standbyReq && (state != MODE_STBY) && !txIn;
    if (standbyReq) begin
      nextState       = MODE_STBY;
      strobe.tmoClear = 1'b1;
    end else begin
      case (state)
        MODE_STBY: begin
          nextState       = MODE_IDLE;
          strobe.tmoClear = 1'b1;
        end
        MODE_IDLE: begin
          if (!txIn) begin
            nextState      = MODE_TX;
            strobe.tmoLoad = 1'b1;
          end else if (validCarrier) begin
            nextState      = MODE_RX;
            strobe.tmoLoad = 1'b1;
          end
        end
        MODE_RX: begin
          if (validCarrier)  strobe.tmoLoad = 1'b1;
          else if (tmoDone)  nextState      = MODE_IDLE;
          else               strobe.tmoRun  = 1'b1;
        end
        MODE_TX: begin
          if (!txIn)         strobe.tmoLoad = 1'b1;
          else if (tmoDone)  nextState      = MODE_IDLE;
          else               strobe.tmoRun  = 1'b1;
        end
        default: nextState = MODE_IDLE;
      endcase
    end
  end

  assign dirOut = (state == MODE_RX);
  assign rxOut  = (state == MODE_RX || state == MODE_STBY) ? !validCarrier : 1'b1;

endmodule

// File: rtl/coaxDirCtl.sv
module coaxDirCtl
  import coaxDirPkg::*;
#(
  parameter int unsigned NOISE_CYC    = 8,
  parameter int unsigned BIT_CYC_SLOW = 907,
  parameter int unsigned BIT_CYC_MID  = 227,
  parameter int unsigned BIT_CYC_FAST = 76,
  parameter int unsigned CARRIER_DIV  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txIn,
  input  logic       carrierDet,
  input  logic [1:0] rateSel,
  output logic       dirOut,
  output logic       rxOut,
  output logic       txCarrier
);

  ctlStrobeT strobe;
  logic      validCarrier;
  logic      tmoDone;

  coaxDirControl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .txIn         (txIn),
    .validCarrier (validCarrier),
    .tmoDone      (tmoDone),
    .rateSel      (rateSel),
    .strobe       (strobe),
    .dirOut       (dirOut),
    .rxOut        (rxOut)
  );

  coaxDirDatapath #(
    .NOISE_CYC    (NOISE_CYC),
    .BIT_CYC_SLOW (BIT_CYC_SLOW),
    .BIT_CYC_MID  (BIT_CYC_MID),
    .BIT_CYC_FAST (BIT_CYC_FAST),
    .CARRIER_DIV  (CARRIER_DIV)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .carrierDet   (carrierDet),
    .rateSel      (rateSel),
    .strobe       (strobe),
    .validCarrier (validCarrier),
    .tmoDone      (tmoDone),
    .txCarrier    (txCarrier)
  );

endmodule

// File: rtl/coaxDirChecker.sv
module coaxDirChecker
  import coaxDirPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       txIn,
  input logic       carrierDet,
  input logic [1:0] rateSel,
  input logic       dirOut,
  input logic       rxOut,
  input logic       txCarrier
);

  // Standby silences the driver and the direction line
  assert_standby_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rateSel == SEL_STANDBY) |=> (!txCarrier && !dirOut));

  // A high transmit line gates the carrier off on the next clock
  assert_carrier_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    txIn |=> !txCarrier);

  // Receive mode is only entered on a carrier that was present
  assert_rx_needs_carrier_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dirOut) |-> $past(carrierDet));

  // A local transmit start outside receive mode keeps rxOut high
  assert_tx_masks_rx_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(txIn) && !dirOut && rateSel != SEL_STANDBY) |=> rxOut);

  // Leaving standby lands in idle
  assert_standby_exit_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rateSel) == SEL_STANDBY && rateSel != SEL_STANDBY)
      |=> (!dirOut && rxOut));

endmodule

bind coaxDirCtl coaxDirChecker u_coaxDirChecker (.*);

// File: tb/tb_coaxDirCtl.sv
module tb_coaxDirCtl;

  localparam int unsigned NF    = 4;
  localparam int unsigned PS    = 12;
  localparam int unsigned PM    = 8;
  localparam int unsigned PF    = 5;
  localparam int unsigned TS    = 16 * PS;
  localparam int unsigned TM    = 16 * PM;
  localparam int unsigned TF    = 16 * PF;
  localparam int unsigned NVEC  = 13;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txIn = 1'b1;
  logic       carrierDet = 1'b0;
  logic [1:0] rateSel = 2'b00;
  logic       dirOut, rxOut, txCarrier;

  int checkCount = 0;
  int failCount  = 0;

  always #5 clk = ~clk;

  coaxDirCtl #(
    .NOISE_CYC(NF), .BIT_CYC_SLOW(PS), .BIT_CYC_MID(PM), .BIT_CYC_FAST(PF), .CARRIER_DIV(4)
  ) dut (
    .clk(clk), .rstN(rstN), .txIn(txIn), .carrierDet(carrierDet), .rateSel(rateSel),
    .dirOut(dirOut), .rxOut(rxOut), .txCarrier(txCarrier)
  );

  // fields: [13:12] sel, [11] txIn, [10] carrier, [9:2] hold clocks, [1] dir, [0] rx
  localparam logic [13:0] VEC [NVEC] = '{
    {2'b10, 1'b1, 1'b0, 8'd3,   1'b0, 1'b1},  // R1 idle
    {2'b10, 1'b1, 1'b1, 8'd3,   1'b0, 1'b1},  // R2 short burst
    {2'b10, 1'b1, 1'b0, 8'd3,   1'b0, 1'b1},  // R2 after burst
    {2'b10, 1'b1, 1'b1, 8'd5,   1'b1, 1'b0},  // R3 enter receive
    {2'b10, 1'b1, 1'b0, 8'd2,   1'b1, 1'b1},  // R3 rxOut follows
    {2'b10, 1'b1, 1'b1, 8'd6,   1'b1, 1'b0},  // R3 new carrier
    {2'b10, 1'b1, 1'b0, 8'd100, 1'b0, 1'b1},  // R4 back to idle
    {2'b10, 1'b0, 1'b0, 8'd2,   1'b0, 1'b1},  // R5 transmit
    {2'b10, 1'b0, 1'b1, 8'd10,  1'b0, 1'b1},  // R6 carrier masked
    {2'b10, 1'b1, 1'b0, 8'd90,  1'b0, 1'b1},  // R7 transmit ends
    {2'b11, 1'b0, 1'b1, 8'd6,   1'b0, 1'b0},  // R10 standby rx
    {2'b11, 1'b0, 1'b0, 8'd2,   1'b0, 1'b1},  // R10 standby idle line
    {2'b00, 1'b1, 1'b0, 8'd2,   1'b0, 1'b1}   // R11 standby exit
  };
  string vecTag [NVEC] = '{"R1", "R2", "R2", "R3", "R3", "R3", "R4",
                           "R5", "R6", "R7", "R10", "R10", "R11"};

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chkDir(input string req, input logic expDir, input logic expRx);
    chk(dirOut === expDir, {req, " dirOut"}, int'(dirOut), int'(expDir));
    chk(rxOut === expRx, {req, " rxOut"}, int'(rxOut), int'(expRx));
  endtask

  task automatic countRises(input int n, output int rises);
    logic prev;
    rises = 0;
    prev  = txCarrier;
    for (int k = 0; k < n; k++) begin
      step(1);
      if (txCarrier && !prev) rises++;
      prev = txCarrier;
    end
  endtask

  task automatic rxTimeout(input logic [1:0] sel, input int t, input string req);
    rateSel = sel;
    carrierDet = 1'b1;
    step(NF + 2);
    chkDir(req, 1'b1, 1'b0);
    carrierDet = 1'b0;
    step(t);
    chkDir(req, 1'b1, 1'b1);
    step(2);
    chkDir(req, 1'b0, 1'b1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin : main
    int rises;
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    chkDir("R1", 1'b0, 1'b1);
    chk(txCarrier == 1'b0, "R1 txCarrier", int'(txCarrier), 0);

    for (int i = 0; i < NVEC; i++) begin
      rateSel    = VEC[i][13:12];
      txIn       = VEC[i][11];
      carrierDet = VEC[i][10];
      step(int'(VEC[i][9:2]));
      chkDir(vecTag[i], VEC[i][1], VEC[i][0]);
    end

    // R9 and R4: timeout length for each rate code
    rxTimeout(2'b00, TS, "R9 slow");
    rxTimeout(2'b01, TM, "R9 mid");
    rxTimeout(2'b10, TF, "R4 fast");

    // R7: transmit hold measured through a carrier waiting behind it
    rateSel = 2'b10;
    txIn = 1'b0; carrierDet = 1'b1;
    step(3);
    txIn = 1'b1;
    step(TF);
    chkDir("R7 hold", 1'b0, 1'b1);
    step(2);
    chkDir("R7 release", 1'b1, 1'b0);
    carrierDet = 1'b0;
    step(TF + 5);
    chkDir("R7 idle", 1'b0, 1'b1);

    // R7: new low on txIn restarts the wait
    txIn = 1'b0; carrierDet = 1'b1;
    step(3);
    txIn = 1'b1;
    step(TF / 2);
    txIn = 1'b0;
    step(1);
    txIn = 1'b1;
    step(TF);
    chkDir("R7 restart hold", 1'b0, 1'b1);
    step(2);
    chkDir("R7 restart release", 1'b1, 1'b0);
    carrierDet = 1'b0;
    step(TF + 5);

    // R8: carrier at a quarter of the clock while txIn low
    txIn = 1'b0;
    step(2);
    countRises(32, rises);
    chk(rises == 8, "R8 carrier rises", rises, 8);
    txIn = 1'b1;
    step(1);
    countRises(16, rises);
    chk(rises == 0, "R8 carrier off", rises, 0);
    step(TF + 5);

    // R10: standby keeps the carrier off with txIn low
    rateSel = 2'b11; txIn = 1'b0;
    step(1);
    countRises(16, rises);
    chk(rises == 0, "R10 standby carrier", rises, 0);
    chk(dirOut == 1'b0, "R10 standby dir", int'(dirOut), 0);
    txIn = 1'b1; rateSel = 2'b10;
    step(2);

    // R11: entering standby from receive drops dirOut next clock
    carrierDet = 1'b1;
    step(NF + 2);
    chkDir("R11 in receive", 1'b1, 1'b0);
    rateSel = 2'b11;
    step(1);
    chkDir("R11 standby entry", 1'b0, 1'b0);
    rateSel = 2'b10; carrierDet = 1'b0;
    step(1);
    chkDir("R11 standby exit", 1'b0, 1'b1);

    // R5: txIn low and carrier in the same cycle picks transmit
    step(3);
    txIn = 1'b0; carrierDet = 1'b1;
    step(NF + 3);
    chkDir("R5 priority", 1'b0, 1'b1);

    // R1: reset in the middle of activity
    rstN = 1'b0;
    #1;
    chkDir("R1 async reset", 1'b0, 1'b1);
    chk(txCarrier == 1'b0, "R1 reset carrier", int'(txCarrier), 0);
    txIn = 1'b1; carrierDet = 1'b0;
    step(2);
    rstN = 1'b1;
    step(2);
    chkDir("R1 after reset", 1'b0, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule